// File: doc/BRIEF.md
# PCI Status and Revision Register Slice

This block holds two configuration-space registers of a PCI function that can act as bus master. The 16-bit status word sits in the upper half of configuration dword 1 (byte offsets 06h–07h). The 8-bit revision byte sits in the low byte of dword 2 (offset 08h). Five sticky error flags are set by single-cycle event pulses from the bus interface logic. Software clears a flag by writing a one to it. All other status fields are fixed values, except the capability-list bit, which follows a strap. The low three revision bits can be replaced by a strap value that the nonvolatile-memory loader supplies.

Software reaches the registers through a simple dword-wide configuration port. The port takes a dword index, per-byte write enables, a write strobe and a read strobe. A small two-state access machine (`ACC_IDLE`, `ACC_RDRESP`) returns read data on the cycle after the read strobe. The machine takes transition `rd` (IDLE→RDRESP, or it stays in RDRESP) when `cfg_rd` is high, and transition `done` (RDRESP→IDLE) when it is low.

Top module: `pci_stat_rev_regs`

## Requirements
- R1: After reset, with `strap_pm_cap`=1 and `strap_rev_valid`=0, the status word reads 0290h and the revision byte reads the `REV_DEFAULT` parameter.
- R2: A read strobe in cycle n gives `cfg_rvalid`=1 and valid `cfg_rdata` in cycle n+1. `cfg_rvalid` is 0 in any cycle that does not follow a read strobe.
- R3: Dword index 1 returns the status word in `cfg_rdata[31:16]` and zero in bits 15:0. Index 2 returns the revision byte in bits 7:0 and zero in bits 31:8. Every other index returns zero.
- R4: Status bit 15 (parity seen) is set by `ev_parity_det` whatever the value of `perr_resp_en`.
- R5: Status bits 14, 13 and 12 are set by `ev_serr`, `ev_mabort` and `ev_tabort_rx` respectively.
- R6: Status bit 8 (data parity as master) is set only when `ev_perr`, `is_master` and `perr_resp_en` are all 1 in the same cycle.
- R7: A write to index 1 with `cfg_be[3]`=1 clears each of status bits 15, 14, 13, 12 and 8 whose matching `cfg_wdata` bit (31, 30, 29, 28, 24) is 1. A zero bit, or `cfg_be[3]`=0, leaves the flag unchanged.
- R8: When a set event and a clearing write hit the same flag in one cycle, the flag ends up set.
- R9: Status bit 11 reads 0, bits 10:9 read 01b, bit 7 reads 1, bits 6:5 and 3:0 read 0. No write changes them, and writes to index 2 leave the revision byte unchanged.
- R10: Status bit 4 always equals `strap_pm_cap`.
- R11: When `strap_rev_valid`=1, revision bits 2:0 equal `strap_rev`, and bits 7:3 keep `REV_DEFAULT[7:3]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_addr | input | ADDR_W | Configuration dword index |
| cfg_rd | input | 1 | Read strobe |
| cfg_wr | input | 1 | Write strobe |
| cfg_be | input | 4 | Byte enables for writes |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, valid with cfg_rvalid |
| cfg_rvalid | output | 1 | Read data valid, one cycle after cfg_rd |
| ev_parity_det | input | 1 | Bus parity error detected pulse |
| ev_serr | input | 1 | System error signalled pulse |
| ev_mabort | input | 1 | Master abort generated pulse |
| ev_tabort_rx | input | 1 | Target abort received pulse |
| ev_perr | input | 1 | Data parity error pulse (asserted on read or seen on write) |
| is_master | input | 1 | Function currently owns the bus |
| perr_resp_en | input | 1 | Parity error response enable from command register |
| strap_pm_cap | input | 1 | Power-management capability strap |
| strap_rev_valid | input | 1 | Revision override strap valid |
| strap_rev | input | 3 | Revision override value |

## Verification
The assertions assume that every input is a known value from the first edge after reset. They also assume that `cfg_addr` and `cfg_wdata` are meaningful in every cycle, because the clear and read-response properties sample them whatever the strobes are. The bench drives all inputs on the falling edge. It holds each strobe and event pulse for exactly one cycle and returns every input to a defined idle value between scenarios, so the properties see only legal, settled values. The strap inputs are changed only while no access is in flight.

// File: rtl/pcistat_pkg.sv
`timescale 1ns/1ps
package pcistat_pkg;
    localparam int FLAG_N = 5;

    typedef enum logic [2:0] {
        FL_DPED = 3'd0,
        FL_RTA  = 3'd1,
        FL_RMA  = 3'd2,
        FL_SSE  = 3'd3,
        FL_DPE  = 3'd4
    } flag_idx_e;

    typedef enum logic [0:0] {
        ACC_IDLE   = 1'b0,
        ACC_RDRESP = 1'b1
    } acc_state_e;

    // status bit position of each sticky flag
    function automatic int flag_pos(input int idx);
        case (idx)
            0:       return 8;
            1:       return 12;
            2:       return 13;
            3:       return 14;
            default: return 15;
        endcase
    endfunction
endpackage

// File: rtl/pcistat_flags.sv
`timescale 1ns/1ps
module pcistat_flags #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q_o
);
    for (genvar g = 0; g < N; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)
                q_o[g] <= 1'b0;
            else
                q_o[g] <= set_i[g] | (q_o[g] & ~clr_i[g]);  // set has priority
        end
    end
endmodule

// File: rtl/pcistat_readmux.sv
`timescale 1ns/1ps
module pcistat_readmux #(
    parameter int          ADDR_W    = 6,
    parameter int          STATUS_DW = 1,
    parameter int          REV_DW    = 2
) (
    input  logic [ADDR_W-1:0] idx_i,
    input  logic [15:0]       status_i,
    input  logic [7:0]        rev_i,
    output logic [31:0]       dword_o
);
    localparam logic [ADDR_W-1:0] STAT_IDX = ADDR_W'(STATUS_DW);
    localparam logic [ADDR_W-1:0] REV_IDX  = ADDR_W'(REV_DW);

    always_comb begin
        dword_o = '0;
        if (idx_i == STAT_IDX)
            dword_o = {status_i, 16'h0000};
        else if (idx_i == REV_IDX)
            dword_o = {24'h000000, rev_i};
    end
endmodule

// File: rtl/pcistat_access_fsm.sv
`timescale 1ns/1ps
module pcistat_access_fsm
    import pcistat_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rd_i,
    input  logic [31:0] word_i,
    output logic        rvalid_o,
    output logic [31:0] rdata_o
);
    acc_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACC_IDLE:   if (rd_i)  state_d = ACC_RDRESP;   // rd
            ACC_RDRESP: if (!rd_i) state_d = ACC_IDLE;     // done
            default:    state_d = ACC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ACC_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    rdata_o <= '0;
        else if (rd_i) rdata_o <= word_i;
    end

    assign rvalid_o = (state_q == ACC_RDRESP);
endmodule

// File: rtl/pci_stat_rev_regs.sv
`timescale 1ns/1ps
module pci_stat_rev_regs
    import pcistat_pkg::*;
#(
    parameter int          ADDR_W      = 6,
    parameter int          STATUS_DW   = 1,
    parameter int          REV_DW      = 2,
    parameter logic [7:0]  REV_DEFAULT = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              cfg_rd,
    input  logic              cfg_wr,
    input  logic [3:0]        cfg_be,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output logic              cfg_rvalid,
    input  logic              ev_parity_det,
    input  logic              ev_serr,
    input  logic              ev_mabort,
    input  logic              ev_tabort_rx,
    input  logic              ev_perr,
    input  logic              is_master,
    input  logic              perr_resp_en,
    input  logic              strap_pm_cap,
    input  logic              strap_rev_valid,
    input  logic [2:0]        strap_rev
);
    localparam logic [ADDR_W-1:0] STAT_IDX = ADDR_W'(STATUS_DW);

    logic [FLAG_N-1:0] flag_set, flag_clr, flag_q;
    logic [15:0]       stat_word;
    logic [7:0]        rev_byte;
    logic [31:0]       mux_word;
    logic              stat_wr_hi;

    // only the upper status byte (byte lane 3) holds writable bits
    assign stat_wr_hi = cfg_wr && (cfg_addr == STAT_IDX) && cfg_be[3];

    always_comb begin
        flag_set          = '0;
        flag_set[FL_DPE]  = ev_parity_det;
        flag_set[FL_SSE]  = ev_serr;
        flag_set[FL_RMA]  = ev_mabort;
        flag_set[FL_RTA]  = ev_tabort_rx;
        flag_set[FL_DPED] = ev_perr && is_master && perr_resp_en;
    end

    for (genvar g = 0; g < FLAG_N; g++) begin : g_clr
        assign flag_clr[g] = stat_wr_hi && cfg_wdata[16 + flag_pos(g)];
    end

    pcistat_flags #(.N(FLAG_N)) i_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (flag_set),
        .clr_i (flag_clr),
        .q_o   (flag_q)
    );

    assign stat_word = {flag_q[FL_DPE], flag_q[FL_SSE], flag_q[FL_RMA], flag_q[FL_RTA],
                        1'b0, 2'b01, flag_q[FL_DPED],
                        1'b1, 2'b00, strap_pm_cap, 4'b0000};

    assign rev_byte = {REV_DEFAULT[7:3], strap_rev_valid ? strap_rev : REV_DEFAULT[2:0]};

    pcistat_readmux #(.ADDR_W(ADDR_W), .STATUS_DW(STATUS_DW), .REV_DW(REV_DW)) i_mux (
        .idx_i    (cfg_addr),
        .status_i (stat_word),
        .rev_i    (rev_byte),
        .dword_o  (mux_word)
    );

    pcistat_access_fsm i_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_i     (cfg_rd),
        .word_i   (mux_word),
        .rvalid_o (cfg_rvalid),
        .rdata_o  (cfg_rdata)
    );

    logic unused_wr_bits;
    assign unused_wr_bits = ^{cfg_be[2:0], cfg_wdata[23:0], cfg_wdata[27:25]};
endmodule

// File: rtl/pcistat_chk.sv
`timescale 1ns/1ps
module pcistat_chk #(
    parameter int ADDR_W    = 6,
    parameter int STATUS_DW = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic              cfg_rd,
    input logic              cfg_wr,
    input logic [3:0]        cfg_be,
    input logic [31:0]       cfg_wdata,
    input logic [31:0]       cfg_rdata,
    input logic              cfg_rvalid,
    input logic              ev_parity_det,
    input logic              ev_mabort,
    input logic              ev_tabort_rx,
    input logic              ev_perr,
    input logic              is_master,
    input logic              perr_resp_en,
    input logic [15:0]       stat
);
    localparam logic [ADDR_W-1:0] STAT_IDX = ADDR_W'(STATUS_DW);

    AST_RD_RESP:      assert property (@(posedge clk) disable iff (!rst_n) cfg_rd |=> cfg_rvalid);   // R2
    AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n) !cfg_rd |=> !cfg_rvalid); // R2
    AST_DPE_SET:      assert property (@(posedge clk) disable iff (!rst_n) ev_parity_det |=> stat[15]); // R4
    AST_RMA_SET:      assert property (@(posedge clk) disable iff (!rst_n) ev_mabort |=> stat[13]);     // R5
    AST_DPED_QUAL:    assert property (@(posedge clk) disable iff (!rst_n)
                          $rose(stat[8]) |-> $past(ev_perr && is_master && perr_resp_en));          // R6
    AST_W1C_ONLY:     assert property (@(posedge clk) disable iff (!rst_n)
                          $fell(stat[15]) |-> $past(cfg_wr && cfg_addr == STAT_IDX && cfg_be[3] && cfg_wdata[31])); // R7
    AST_SET_WINS:     assert property (@(posedge clk) disable iff (!rst_n)
                          (ev_tabort_rx && cfg_wr && cfg_addr == STAT_IDX && cfg_be[3] && cfg_wdata[28]) |=> stat[12]); // R8
    AST_FIXED_READ:   assert property (@(posedge clk) disable iff (!rst_n)
                          (cfg_rvalid && $past(cfg_addr == STAT_IDX)) |->
                          (cfg_rdata[27:25] == 3'b001 && cfg_rdata[23:21] == 3'b100
                           && cfg_rdata[19:0] == 20'h0));                                          // R9
endmodule

bind pci_stat_rev_regs pcistat_chk #(.ADDR_W(ADDR_W), .STATUS_DW(STATUS_DW)) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_addr      (cfg_addr),
    .cfg_rd        (cfg_rd),
    .cfg_wr        (cfg_wr),
    .cfg_be        (cfg_be),
    .cfg_wdata     (cfg_wdata),
    .cfg_rdata     (cfg_rdata),
    .cfg_rvalid    (cfg_rvalid),
    .ev_parity_det (ev_parity_det),
    .ev_mabort     (ev_mabort),
    .ev_tabort_rx  (ev_tabort_rx),
    .ev_perr       (ev_perr),
    .is_master     (is_master),
    .perr_resp_en  (perr_resp_en),
    .stat          (stat_word)
);

// File: tb/test_pci_stat_rev_regs.sv
`timescale 1ns/1ps
module test_pci_stat_rev_regs;
    localparam logic [7:0] REV_DEF = 8'hAB;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic        cfg_rd = 1'b0, cfg_wr = 1'b0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        cfg_rvalid;
    logic        ev_parity_det = 0, ev_serr = 0, ev_mabort = 0, ev_tabort_rx = 0, ev_perr = 0;
    logic        is_master = 0, perr_resp_en = 0;
    logic        strap_pm_cap = 1, strap_rev_valid = 0;
    logic [2:0]  strap_rev = 3'b000;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;  // 125 MHz

    pci_stat_rev_regs #(.REV_DEFAULT(REV_DEF)) i_pci_stat_rev_regs (
        .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_rd(cfg_rd), .cfg_wr(cfg_wr),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_rvalid(cfg_rvalid),
        .ev_parity_det(ev_parity_det), .ev_serr(ev_serr), .ev_mabort(ev_mabort),
        .ev_tabort_rx(ev_tabort_rx), .ev_perr(ev_perr), .is_master(is_master),
        .perr_resp_en(perr_resp_en), .strap_pm_cap(strap_pm_cap),
        .strap_rev_valid(strap_rev_valid), .strap_rev(strap_rev)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d, output logic v);
        @(negedge clk);
        cfg_addr = a; cfg_rd = 1'b1;
        @(negedge clk);
        cfg_rd = 1'b0;
        d = cfg_rdata; v = cfg_rvalid;
    endtask

    task automatic rd_stat(output logic [15:0] s);
        logic [31:0] d; logic v;
        rd(6'd1, d, v);
        s = d[31:16];
    endtask

    task automatic wr(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        cfg_addr = a; cfg_be = be; cfg_wdata = d; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_be = '0; cfg_wdata = '0;
    endtask

    task automatic clear_all;
        wr(6'd1, 4'hF, 32'hFFFF_FFFF);
    endtask

    task automatic t_reset;
        logic [31:0] d; logic v;
        check("R2 idle rvalid", {31'd0, cfg_rvalid}, 32'd0);
        rd(6'd1, d, v);
        check("R1 status reset", d, 32'h0290_0000);
        rd(6'd2, d, v);
        check("R1 revision reset", d, {24'd0, REV_DEF});
    endtask

    task automatic t_latency_map;
        logic [31:0] d; logic v;
        rd(6'd1, d, v);
        check("R2 rvalid after rd", {31'd0, v}, 32'd1);
        @(negedge clk);
        check("R2 rvalid drops", {31'd0, cfg_rvalid}, 32'd0);
        rd(6'd0, d, v);
        check("R3 index 0 zero", d, 32'd0);
        rd(6'd3, d, v);
        check("R3 index 3 zero", d, 32'd0);
        rd(6'd63, d, v);
        check("R3 index 63 zero", d, 32'd0);
    endtask

    task automatic t_parity;
        logic [15:0] s;
        perr_resp_en = 1'b0;
        @(negedge clk); ev_parity_det = 1'b1;
        @(negedge clk); ev_parity_det = 1'b0;
        rd_stat(s);
        check("R4 parity sets bit15 with resp off", {16'd0, s}, 32'h8290);
        clear_all;
    endtask

    task automatic t_events;
        logic [15:0] s;
        @(negedge clk); ev_serr = 1'b1;
        @(negedge clk); ev_serr = 1'b0;
        rd_stat(s);
        check("R5 serr sets bit14", {16'd0, s}, 32'h4290);
        clear_all;
        @(negedge clk); ev_mabort = 1'b1;
        @(negedge clk); ev_mabort = 1'b0;
        rd_stat(s);
        check("R5 mabort sets bit13", {16'd0, s}, 32'h2290);
        clear_all;
        @(negedge clk); ev_tabort_rx = 1'b1;
        @(negedge clk); ev_tabort_rx = 1'b0;
        rd_stat(s);
        check("R5 tabort sets bit12", {16'd0, s}, 32'h1290);
        clear_all;
    endtask

    task automatic dped_try(input logic m, input logic en, input logic [15:0] exp, input string tag);
        logic [15:0] s;
        @(negedge clk); is_master = m; perr_resp_en = en; ev_perr = 1'b1;
        @(negedge clk); ev_perr = 1'b0; is_master = 1'b0; perr_resp_en = 1'b0;
        rd_stat(s);
        check(tag, {16'd0, s}, {16'd0, exp});
        clear_all;
    endtask

    task automatic t_dped;
        dped_try(1'b0, 1'b1, 16'h0290, "R6 not master no set");
        dped_try(1'b1, 1'b0, 16'h0290, "R6 resp off no set");
        dped_try(1'b1, 1'b1, 16'h0390, "R6 all three set bit8");
    endtask

    task automatic set_all_flags;
        @(negedge clk);
        ev_parity_det = 1; ev_serr = 1; ev_mabort = 1; ev_tabort_rx = 1;
        ev_perr = 1; is_master = 1; perr_resp_en = 1;
        @(negedge clk);
        ev_parity_det = 0; ev_serr = 0; ev_mabort = 0; ev_tabort_rx = 0;
        ev_perr = 0; is_master = 0; perr_resp_en = 0;
    endtask

    task automatic t_w1c;
        logic [15:0] s;
        set_all_flags;
        rd_stat(s);
        check("R7 all flags set", {16'd0, s}, 32'hF390);
        wr(6'd1, 4'h7, 32'hFFFF_FFFF);
        rd_stat(s);
        check("R7 be3 off keeps flags", {16'd0, s}, 32'hF390);
        wr(6'd1, 4'hF, 32'h0000_0000);
        rd_stat(s);
        check("R7 zero write keeps flags", {16'd0, s}, 32'hF390);
        wr(6'd0, 4'hF, 32'hFFFF_FFFF);
        rd_stat(s);
        check("R7 other index keeps flags", {16'd0, s}, 32'hF390);
        wr(6'd1, 4'h8, 32'hA100_0000);
        rd_stat(s);
        check("R7 clears bits 15 13 8", {16'd0, s}, 32'h5290);
        clear_all;
        rd_stat(s);
        check("R7 all cleared", {16'd0, s}, 32'h0290);
    endtask

    task automatic t_set_wins;
        logic [15:0] s;
        @(negedge clk);
        ev_tabort_rx = 1'b1;
        cfg_addr = 6'd1; cfg_be = 4'h8; cfg_wdata = 32'h1000_0000; cfg_wr = 1'b1;
        @(negedge clk);
        ev_tabort_rx = 1'b0; cfg_wr = 1'b0; cfg_be = '0; cfg_wdata = '0;
        rd_stat(s);
        check("R8 set beats clear", {16'd0, s}, 32'h1290);
        clear_all;
    endtask

    task automatic t_readonly;
        logic [31:0] d; logic v;
        wr(6'd1, 4'hF, 32'h0000_0000);
        wr(6'd1, 4'hC, 32'h0E6F_FFFF);
        rd(6'd1, d, v);
        check("R9 fixed bits after writes", d, 32'h0290_0000);
        wr(6'd2, 4'hF, 32'hFFFF_FF00);
        rd(6'd2, d, v);
        check("R9 revision write ignored", d, {24'd0, REV_DEF});
    endtask

    task automatic t_strap_cap;
        logic [15:0] s;
        @(negedge clk); strap_pm_cap = 1'b0;
        rd_stat(s);
        check("R10 cap strap low", {16'd0, s}, 32'h0280);
        @(negedge clk); strap_pm_cap = 1'b1;
        rd_stat(s);
        check("R10 cap strap high", {16'd0, s}, 32'h0290);
    endtask

    task automatic t_rev;
        logic [31:0] d; logic v;
        @(negedge clk); strap_rev = 3'b101; strap_rev_valid = 1'b0;
        rd(6'd2, d, v);
        check("R11 invalid strap ignored", d, {24'd0, REV_DEF});
        @(negedge clk); strap_rev_valid = 1'b1;
        rd(6'd2, d, v);
        check("R11 override low bits", d, {24'd0, REV_DEF[7:3], 3'b101});
        @(negedge clk); strap_rev = 3'b000;
        rd(6'd2, d, v);
        check("R11 override zero", d, {24'd0, REV_DEF[7:3], 3'b000});
        @(negedge clk); strap_rev_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_latency_map;
        t_parity;
        t_events;
        t_dped;
        t_w1c;
        t_set_wins;
        t_readonly;
        t_strap_cap;
        t_rev;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule